// File: doc/BRIEF.md
# Processor Interrupt Control Unit

This unit gathers interrupt requests for a small 8-bit processor core and decides when the core must leave its current program flow. Three core sources are handled: an asynchronous external pin with a selectable edge, a port-change event pulse and a timer overflow pulse. Each source has a sticky request flag and its own mask bit. A group of peripheral sources has its own flag register and its own enable register. The whole peripheral group passes through a single group enable bit, and every source passes through a global enable.

When a masked-in flag is pending and the global enable is set, the unit raises `irq_req_o`. The core answers with `irq_ack_i`. The unit then pulses `take_o` for one cycle, which tells the core to push its return address and load the fixed vector on `vector_o`. At the same edge the global enable is cleared. A return strobe `reti_i` sets the global enable again. Flags are cleared only by software. A flag that is still set when the global enable comes back raises the request again straight away.

Software reaches four 8-bit registers through one address port. Writes take effect at the clock edge. Read data is registered and shows the register contents as they were before that edge.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the global enable, the group enable, all flags and all enables are 0, the edge-select bit is 1, and `irq_req_o` and `take_o` are 0.
- R2: A pulse on `chg_evt_i` or `tmr_ovf_i` sets its flag at that clock edge. The flags read back in the control register (address 0) at bit 4 for port change and bit 5 for timer, with bit 3 for the pin. If the source is enabled (bit 1 for change, bit 2 for timer, bit 0 for pin) and the global enable (bit 7) is set, `irq_req_o` is 1 after that same edge.
- R3: A flag stays set until a software write puts a 0 into it. If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R4: The pin is passed through two synchronising flops. The option register (address 3) bit 0 selects rising (1) or falling (0) edges. The selected edge, present at the pin before clock edge k, sets the pin flag at edge k+2. The other edge direction sets nothing.
- R5: While the global enable is 0, `irq_req_o` stays 0 whatever flags are pending.
- R6: `irq_req_o` is 1 exactly when the global enable is set and some source has both its flag and its enable set. For peripheral sources, the group enable must also be set.
- R7: Peripheral flags (address 1) and peripheral enables (address 2) take bits NPER-1:0. They contribute to the request only when the group enable (control bit 6) is 1.
- R8: `irq_ack_i` while `irq_req_o` is 1 gives a one-cycle `take_o` pulse after that edge. It also clears the global enable and drops `irq_req_o`. `vector_o` holds 0x0004. An acknowledge while no request is raised does nothing.
- R9: `reti_i` sets the global enable. If a flag is still pending and enabled, `irq_req_o` is 1 after that edge.
- R10: `rdata_o` shows, one edge after an address is presented, the pre-edge contents of that register. Bits that are not implemented read 0.
- R11: For the global enable, an accepted acknowledge takes priority over `reti_i`, and `reti_i` takes priority over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register address for read and write |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| chg_evt_i | input | 1 | Port-change event pulse |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| per_evt_i | input | NPER | Peripheral event pulses |
| irq_ack_i | input | 1 | Core accepts the pending interrupt |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Interrupt request to the core |
| take_o | output | 1 | One-cycle push-and-jump command |
| vector_o | output | PC_W | Interrupt vector address |

## Verification
The bench builds the unit with NPER set to 5 and two synchroniser stages. The narrower peripheral width brings unimplemented register bits into reach, so writes to bits 7:5 of the peripheral registers can be shown to read back as zero. Two stages fix the pin-to-flag delay at a known edge count, so the bench can check the cycle before and the cycle of the flag's arrival for both edge polarities.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int NCORE  = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CORE  = 2'd0,
    RA_PFLAG = 2'd1,
    RA_PEN   = 2'd2,
    RA_OPT   = 2'd3
  } reg_addr_e;

  // control register layout; core sources are ordered pin, change, timer
  localparam int CB_EN_LO = 0;
  localparam int CB_FL_LO = 3;
  localparam int CB_PGEN  = 6;
  localparam int CB_GIE   = 7;

  localparam int SRC_PIN = 0;
  localparam int SRC_CHG = 1;
  localparam int SRC_TMR = 2;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;
  logic              last_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chain_q <= '0;
      hist_q  <= 1'b0;
    end else begin
      chain_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      hist_q <= chain_q[STAGES-1];
    end
  end

  assign last_w = chain_q[STAGES-1];
  assign edge_o = rise_sel_i ? (last_w & ~hist_q) : (~last_w & hist_q);

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_o |=> (!edge_o || (rise_sel_i != $past(rise_sel_i))))
    else $error("pin edge lasted more than one cycle"); // R4
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] next_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic bit_q;
    logic bit_n;
    // hardware set overrides a same-cycle software clear
    assign bit_n = (wr_i ? wdata_i[g] : bit_q) | set_i[g];
    always_ff @(posedge clk_i) begin
      if (rst_i) bit_q <= 1'b0;
      else       bit_q <= bit_n;
    end
    assign flag_o[g] = bit_q;
    assign next_o[g] = bit_n;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)))
    else $error("hardware flag set was lost"); // R3
  AST_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)))
    else $error("flag cleared without a write"); // R3
endmodule

// File: rtl/irq_accept.sv
module irq_accept (
  input  logic clk_i,
  input  logic rst_i,
  input  logic gie_wr_i,
  input  logic gie_wdata_i,
  input  logic reti_i,
  input  logic ack_i,
  input  logic pend_next_i,
  output logic gie_o,
  output logic req_o,
  output logic take_o
);
  logic gie_q, req_q, take_q;
  logic take_c, gie_n;

  assign take_c = ack_i & req_q;

  always_comb begin
    if (take_c)        gie_n = 1'b0;
    else if (reti_i)   gie_n = 1'b1;
    else if (gie_wr_i) gie_n = gie_wdata_i;
    else               gie_n = gie_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gie_q  <= 1'b0;
      req_q  <= 1'b0;
      take_q <= 1'b0;
    end else begin
      gie_q  <= gie_n;
      req_q  <= gie_n & pend_next_i;
      take_q <= take_c;
    end
  end

  assign gie_o  = gie_q;
  assign req_o  = req_q;
  assign take_o = take_q;

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    rst_i |=> (!gie_q && !req_q && !take_q))
    else $error("not idle after reset"); // R1
  AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_i && req_q) |=> (take_q && !gie_q && !req_q))
    else $error("accept did not clear global enable"); // R8
  AST_TAKE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    take_q |=> !take_q)
    else $error("take longer than one cycle"); // R8
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_i && !req_q) |=> !take_q)
    else $error("acknowledge without request was taken"); // R8
  AST_RETI_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    (reti_i && !(ack_i && req_q)) |=> gie_q)
    else $error("return strobe did not set global enable"); // R9
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_pkg::*;
#(
  parameter int NPER        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PC_W        = 13,
  parameter int VECTOR_ADDR = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              ext_pin_i,
  input  logic              chg_evt_i,
  input  logic              tmr_ovf_i,
  input  logic [NPER-1:0]   per_evt_i,
  input  logic              irq_ack_i,
  input  logic              reti_i,
  output logic              irq_req_o,
  output logic              take_o,
  output logic [PC_W-1:0]   vector_o
);
  localparam logic [PC_W-1:0] VEC = PC_W'(VECTOR_ADDR);

  logic wr_core, wr_pflag, wr_pen, wr_opt;
  logic pin_edge;
  logic [NCORE-1:0] cset, cflag_q, cflag_n, cen_q, cen_n;
  logic [NPER-1:0]  pflag_q, pflag_n, pen_q, pen_n;
  logic pgen_q, pgen_n, rise_q, gie_w;
  logic core_pend, per_pend, pend_next;
  logic [REG_W-1:0] rd_c, rdata_q;

  assign wr_core  = wr_en_i && (addr_i == RA_CORE);
  assign wr_pflag = wr_en_i && (addr_i == RA_PFLAG);
  assign wr_pen   = wr_en_i && (addr_i == RA_PEN);
  assign wr_opt   = wr_en_i && (addr_i == RA_OPT);

  irq_pin_sync #(.STAGES(SYNC_STAGES)) pin_sync_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pin_i      (ext_pin_i),
    .rise_sel_i (rise_q),
    .edge_o     (pin_edge)
  );

  always_comb begin
    cset          = '0;
    cset[SRC_PIN] = pin_edge;
    cset[SRC_CHG] = chg_evt_i;
    cset[SRC_TMR] = tmr_ovf_i;
  end

  irq_flag_bank #(.W(NCORE)) core_flags_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (wr_core),
    .wdata_i (wdata_i[CB_FL_LO +: NCORE]),
    .set_i   (cset),
    .flag_o  (cflag_q),
    .next_o  (cflag_n)
  );

  irq_flag_bank #(.W(NPER)) per_flags_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (wr_pflag),
    .wdata_i (wdata_i[NPER-1:0]),
    .set_i   (per_evt_i),
    .flag_o  (pflag_q),
    .next_o  (pflag_n)
  );

  assign cen_n  = wr_core ? wdata_i[CB_EN_LO +: NCORE] : cen_q;
  assign pgen_n = wr_core ? wdata_i[CB_PGEN] : pgen_q;
  assign pen_n  = wr_pen  ? wdata_i[NPER-1:0] : pen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cen_q  <= '0;
      pgen_q <= 1'b0;
      pen_q  <= '0;
      rise_q <= 1'b1;
    end else begin
      cen_q  <= cen_n;
      pgen_q <= pgen_n;
      pen_q  <= pen_n;
      if (wr_opt) rise_q <= wdata_i[0];
    end
  end

  // request is formed from post-edge state, so it carries no extra cycle
  assign core_pend = |(cflag_n & cen_n);
  assign per_pend  = pgen_n & (|(pflag_n & pen_n));
  assign pend_next = core_pend | per_pend;

  irq_accept accept_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .gie_wr_i    (wr_core),
    .gie_wdata_i (wdata_i[CB_GIE]),
    .reti_i      (reti_i),
    .ack_i       (irq_ack_i),
    .pend_next_i (pend_next),
    .gie_o       (gie_w),
    .req_o       (irq_req_o),
    .take_o      (take_o)
  );

  always_comb begin
    rd_c = '0;
    unique case (reg_addr_e'(addr_i))
      RA_CORE: begin
        rd_c[CB_GIE]               = gie_w;
        rd_c[CB_PGEN]              = pgen_q;
        rd_c[CB_FL_LO +: NCORE]    = cflag_q;
        rd_c[CB_EN_LO +: NCORE]    = cen_q;
      end
      RA_PFLAG: rd_c[NPER-1:0] = pflag_q;
      RA_PEN:   rd_c[NPER-1:0] = pen_q;
      RA_OPT:   rd_c[0]        = rise_q;
      default:  rd_c = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else        rdata_q <= rd_c;
  end

  assign rdata_o  = rdata_q;
  assign vector_o = VEC;

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (rst_i)
    !gie_w |-> !irq_req_o)
    else $error("request while globally disabled"); // R5
  AST_REQ_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_req_o |-> ((|(cflag_q & cen_q)) || (pgen_q && (|(pflag_q & pen_q)))))
    else $error("request without an enabled flag"); // R6
  AST_PER_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pgen_q && !(|(cflag_q & cen_q))) |-> !irq_req_o)
    else $error("peripheral request passed closed group gate"); // R7
  AST_RD_GIE: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i == RA_CORE) |=> (rdata_o[CB_GIE] == $past(gie_w)))
    else $error("read data does not show global enable"); // R10
endmodule

// File: tb/irq_ctrl_unit_tb.sv
`timescale 1ns/1ps
module irq_ctrl_unit_tb_top;
  localparam int NPER = 5;
  localparam int PC_W = 13;

  logic            clk = 1'b0;
  logic            rst_s = 1'b1;
  logic [1:0]      addr_s = '0;
  logic            wr_s = 1'b0;
  logic [7:0]      wdata_s = '0;
  logic [7:0]      rdata_w;
  logic            pin_s = 1'b0;
  logic            chg_s = 1'b0;
  logic            tmr_s = 1'b0;
  logic [NPER-1:0] per_s = '0;
  logic            ack_s = 1'b0;
  logic            reti_s = 1'b0;
  logic            req_w, take_w;
  logic [PC_W-1:0] vec_w;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic            m_gie, m_pgen, m_rise, m_req, m_take;
  logic [2:0]      m_cfl, m_cen;
  logic [NPER-1:0] m_pfl, m_pen;

  always #10 clk = ~clk;

  irq_ctrl_unit #(.NPER(NPER), .SYNC_STAGES(2), .PC_W(PC_W), .VECTOR_ADDR(4)) dut_i (
    .clk_i(clk), .rst_i(rst_s), .addr_i(addr_s), .wr_en_i(wr_s), .wdata_i(wdata_s),
    .rdata_o(rdata_w), .ext_pin_i(pin_s), .chg_evt_i(chg_s), .tmr_ovf_i(tmr_s),
    .per_evt_i(per_s), .irq_ack_i(ack_s), .reti_i(reti_s), .irq_req_o(req_w),
    .take_o(take_w), .vector_o(vec_w)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic [7:0] r = '0;
    case (a)
      2'd0: r = {m_gie, m_pgen, m_cfl, m_cen};
      2'd1: r[NPER-1:0] = m_pfl;
      2'd2: r[NPER-1:0] = m_pen;
      default: r[0] = m_rise;
    endcase
    return r;
  endfunction

  function automatic logic exp_req(input logic g, pg, input logic [2:0] cf, ce,
                                   input logic [NPER-1:0] pf, pe);
    return g & ((|(cf & ce)) | (pg & (|(pf & pe))));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                      input logic chg, input logic tmr, input logic [NPER-1:0] per,
                      input logic ack, input logic rt, input logic pe);
    logic [7:0] e_rd;
    logic tk, g_n, pg_n, r_n;
    logic [2:0] cf_n, ce_n;
    logic [NPER-1:0] pf_n, pn_n;
    wr_s = wr; addr_s = a; wdata_s = d; chg_s = chg; tmr_s = tmr;
    per_s = per; ack_s = ack; reti_s = rt;
    e_rd = exp_read(a);
    tk   = ack & m_req;
    cf_n = ((wr && a == 2'd0) ? d[5:3] : m_cfl) | {tmr, chg, pe};
    ce_n = (wr && a == 2'd0) ? d[2:0] : m_cen;
    pg_n = (wr && a == 2'd0) ? d[6] : m_pgen;
    g_n  = tk ? 1'b0 : rt ? 1'b1 : (wr && a == 2'd0) ? d[7] : m_gie;
    pf_n = ((wr && a == 2'd1) ? d[NPER-1:0] : m_pfl) | per;
    pn_n = (wr && a == 2'd2) ? d[NPER-1:0] : m_pen;
    if (wr && a == 2'd3) m_rise = d[0];
    r_n  = exp_req(g_n, pg_n, cf_n, ce_n, pf_n, pn_n);
    m_cfl = cf_n; m_cen = ce_n; m_pgen = pg_n; m_gie = g_n;
    m_pfl = pf_n; m_pen = pn_n; m_req = r_n; m_take = tk;
    @(posedge clk);
    @(negedge clk);
    wr_s = 1'b0; chg_s = 1'b0; tmr_s = 1'b0; per_s = '0; ack_s = 1'b0; reti_s = 1'b0;
    chk("R6 request vs model", 32'(req_w), 32'(m_req));
    chk("R8 take vs model", 32'(take_w), 32'(m_take));
    chk("R10 read data vs model", 32'(rdata_w), 32'(e_rd));
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic [1:0] a, input logic pe);
    step(1'b0, a, 8'h00, 1'b0, 1'b0, '0, 1'b0, 1'b0, pe);
  endtask

  initial begin
    for (int i = 0; i < 50000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd7351);
    m_gie = 0; m_pgen = 0; m_rise = 1; m_req = 0; m_take = 0;
    m_cfl = '0; m_cen = '0; m_pfl = '0; m_pen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_s = 1'b0;
    // R1 reset state
    chk("R1 request after reset", 32'(req_w), 32'd0);
    chk("R1 take after reset", 32'(take_w), 32'd0);
    chk("R8 vector value", 32'(vec_w), 32'h4);
    idle(2'd0, 1'b0);
    chk("R1 control reads zero", 32'(rdata_w), 32'h00);
    idle(2'd3, 1'b0);
    chk("R1 edge select reads one", 32'(rdata_w), 32'h01);

    // R2 timer source
    wr_reg(2'd0, 8'h84);
    chk("R2 no request before event", 32'(req_w), 32'd0);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0);
    chk("R2 timer event raises request", 32'(req_w), 32'd1);
    idle(2'd0, 1'b0);
    chk("R2 timer flag at bit 5", 32'(rdata_w[5]), 32'd1);

    // R3 sticky and set-wins
    idle(2'd0, 1'b0); idle(2'd0, 1'b0);
    chk("R3 flag held", 32'(req_w), 32'd1);
    step(1'b1, 2'd0, 8'h84, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0);
    chk("R3 set beats clear", 32'(req_w), 32'd1);
    wr_reg(2'd0, 8'h84);
    chk("R3 software clear", 32'(req_w), 32'd0);

    // R6 masking
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R6 masked change event", 32'(req_w), 32'd0);
    idle(2'd0, 1'b0);
    chk("R6 masked flag still recorded", 32'(rdata_w[4]), 32'd1);
    wr_reg(2'd0, 8'h84);

    // R5 global gate
    wr_reg(2'd0, 8'h04);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0);
    chk("R5 blocked by global enable", 32'(req_w), 32'd0);
    wr_reg(2'd0, 8'hA4);
    chk("R5 request once enabled", 32'(req_w), 32'd1);
    wr_reg(2'd0, 8'h00);

    // R7 peripheral group
    wr_reg(2'd2, 8'h04);
    wr_reg(2'd0, 8'h80);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 5'b00100, 1'b0, 1'b0, 1'b0);
    chk("R7 group gate closed", 32'(req_w), 32'd0);
    wr_reg(2'd0, 8'hC0);
    chk("R7 group gate open", 32'(req_w), 32'd1);
    wr_reg(2'd1, 8'h00);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 5'b00010, 1'b0, 1'b0, 1'b0);
    chk("R7 unenabled peripheral", 32'(req_w), 32'd0);
    wr_reg(2'd1, 8'hFF);
    idle(2'd1, 1'b0);
    chk("R10 unimplemented bits read zero", 32'(rdata_w), 32'h1F);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h00);

    // R4 pin rising then falling
    wr_reg(2'd0, 8'h81);
    pin_s = 1'b1;
    idle(2'd0, 1'b0);
    idle(2'd0, 1'b0);
    chk("R4 rising not yet flagged", 32'(req_w), 32'd0);
    idle(2'd0, 1'b1);
    chk("R4 rising flagged at third edge", 32'(req_w), 32'd1);
    wr_reg(2'd0, 8'h81);
    pin_s = 1'b0;
    for (int i = 0; i < 3; i++) idle(2'd0, 1'b0);
    chk("R4 falling ignored when rising selected", 32'(req_w), 32'd0);
    wr_reg(2'd3, 8'h00);
    pin_s = 1'b1;
    for (int i = 0; i < 3; i++) idle(2'd0, 1'b0);
    chk("R4 rising ignored when falling selected", 32'(req_w), 32'd0);
    pin_s = 1'b0;
    idle(2'd0, 1'b0);
    idle(2'd0, 1'b0);
    chk("R4 falling not yet flagged", 32'(req_w), 32'd0);
    idle(2'd0, 1'b1);
    chk("R4 falling flagged", 32'(req_w), 32'd1);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd3, 8'h01);

    // R8 R9 R11 accept and return
    wr_reg(2'd0, 8'h84);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk("R8 take pulse", 32'(take_w), 32'd1);
    chk("R8 request dropped", 32'(req_w), 32'd0);
    idle(2'd0, 1'b0);
    chk("R8 take one cycle", 32'(take_w), 32'd0);
    chk("R8 global enable cleared", 32'(rdata_w[7]), 32'd0);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk("R8 ack without request ignored", 32'(take_w), 32'd0);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    chk("R9 uncleared flag re-requests", 32'(req_w), 32'd1);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0);
    chk("R11 accept beats return", 32'(req_w), 32'd0);
    step(1'b1, 2'd0, 8'h24, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
    chk("R11 return beats software write", 32'(req_w), 32'd1);
    wr_reg(2'd0, 8'h00);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic w, c, t, k, r;
      logic [1:0] a;
      logic [7:0] d;
      logic [NPER-1:0] p;
      w = ($urandom % 4) == 0;
      a = 2'($urandom % 4);
      d = 8'($urandom);
      c = ($urandom % 8) == 0;
      t = ($urandom % 8) == 0;
      p = (($urandom % 6) == 0) ? NPER'($urandom) : '0;
      k = ($urandom % 3) == 0;
      r = ($urandom % 6) == 0;
      step(w, a, d, c, t, p, k, r, 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule